// File: doc/BRIEF.md
# UART Interrupt Source Prioritiser

This block collects the five interrupt conditions of an asynchronous serial port: receive line error, receive data ready, receive character timeout, transmitter holding register empty and modem status change. It masks them with a four-bit enable value and publishes the highest-priority surviving condition as an 8-bit identification byte. The same result drives a single active-high interrupt line to the host.

The serial datapath, the FIFOs and the timeout counter sit elsewhere. The block sees them only as level or single-cycle pulse inputs. Three conditions are event-type and are held in sticky flags: line error, holding register empty and modem change. Host access strobes clear these flags as a side effect of the accesses. The two receive conditions are plain levels that the block follows. While the host reads the identification byte over several cycles, the byte stays frozen at the value it had on the first cycle of the read.

Top module: `uirq_top`

## Requirements
- R1: Reporting priority from highest to lowest is: line error, then receive timeout or receive data, then holding register empty, then modem change. When timeout and data are both active at the middle level, the timeout code is reported.
- R2: Identification bits [3:0] read 0110 for line error, 1100 for timeout, 0100 for receive data, 0010 for holding register empty, 0000 for modem change, and 0001 when nothing is pending. Bit 0 is therefore 0 exactly when a source is reported.
- R3: The timeout input is ignored when `fifo_en` is 0. In that case identification bit 3 always reads 0.
- R4: Identification bits [5:4] always read 00. Bits [7:6] both read the value of `fifo_en`.
- R5: `ien[0]` enables receive data and timeout, `ien[1]` enables holding register empty, `ien[2]` enables line error and `ien[3]` enables modem change. With `ien` = 0000, `irq` stays low. A sticky flag set while its enable is off stays latched and is reported once the enable is set.
- R6: `irq` is high exactly when at least one enabled source is pending. Outside an identification read, `irq` equals the inverse of identification bit 0.
- R7: A `lsr_err` pulse sets the line error flag from the next cycle. `rd_lsr` clears it. When both arrive in the same cycle, the flag ends up set.
- R8: A `msr_delta` pulse sets the modem change flag from the next cycle. `rd_msr` clears it. When both arrive in the same cycle, the flag ends up set.
- R9: The receive data and timeout sources follow their input levels in the same cycle, with no latching.
- R10: A rising edge on `thr_empty` sets the holding-empty flag. `wr_thr` clears it. The first cycle of an identification read also clears it, but only if holding-empty is the source being reported. A read that reports a different source leaves the flag set.
- R11: While `rd_iir` stays high for several cycles, `iir` holds the value it had in the first cycle of that read. When `rd_iir` drops, `iir` shows the live value again.
- R12: After reset, with `fifo_en` low, `iir` reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 4 | Interrupt enable bits |
| fifo_en | input | 1 | FIFO mode selected |
| lsr_err | input | 1 | Receive line error event (pulse) |
| rx_ready | input | 1 | Receive data available (level) |
| rx_tmo | input | 1 | Receive character timeout (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| msr_delta | input | 1 | Modem status change event (pulse) |
| rd_iir | input | 1 | Identification byte read strobe |
| rd_lsr | input | 1 | Line status read strobe |
| rd_msr | input | 1 | Modem status read strobe |
| wr_thr | input | 1 | Holding register write strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A sticky flag that is lost or stuck shows up in the identification code and on `irq` in the cycle after the event or clear strobe. An exhaustive sweep over every mix of pending sources, enable values and both FIFO settings therefore exposes such a fault within two cycles of the mix that triggers it. A wrong snapshot control shows up as `iir` changing in the second cycle of a held read. A wrong holding-empty clear shows up as the wrong code one cycle after an identification read begins.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int EN_W   = 4;
  localparam int CODE_W = 4;
  localparam int ID_W   = 8;

  // indices of the sticky flags
  localparam int SF_LINE  = 0;
  localparam int SF_TXE   = 1;
  localparam int SF_MODEM = 2;
  localparam int SF_N     = 3;

  // identification codes, bits [3:0]
  localparam logic [CODE_W-1:0] ID_LINE  = 4'b0110;
  localparam logic [CODE_W-1:0] ID_TMO   = 4'b1100;
  localparam logic [CODE_W-1:0] ID_RXD   = 4'b0100;
  localparam logic [CODE_W-1:0] ID_TXE   = 4'b0010;
  localparam logic [CODE_W-1:0] ID_MODEM = 4'b0000;
  localparam logic [CODE_W-1:0] ID_NONE  = 4'b0001;
endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // a new event wins over a clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign pend_o[i] = q;
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  logic              line_i,
  input  logic              tmo_i,
  input  logic              rxd_i,
  input  logic              txe_i,
  input  logic              modem_i,
  output logic [CODE_W-1:0] code_o,
  output logic              any_o
);
  always_comb begin
    if (line_i)       code_o = ID_LINE;
    else if (tmo_i)   code_o = ID_TMO;
    else if (rxd_i)   code_o = ID_RXD;
    else if (txe_i)   code_o = ID_TXE;
    else if (modem_i) code_o = ID_MODEM;
    else              code_o = ID_NONE;
  end
  assign any_o = line_i | tmo_i | rxd_i | txe_i | modem_i;
endmodule

// File: rtl/uirq_snap.sv
module uirq_snap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_i,
  input  logic [W-1:0] live_i,
  output logic         rd_start_o,
  output logic [W-1:0] view_o
);
  logic         rd_q;
  logic [W-1:0] held_q;

  assign rd_start_o = rd_i & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      held_q <= '0;
    end else begin
      rd_q <= rd_i;
      if (rd_start_o) held_q <= live_i;
    end
  end

  assign view_o = (rd_i && rd_q) ? held_q : live_i;
endmodule

// File: rtl/uirq_top.sv
module uirq_top
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] ien,
  input  logic            fifo_en,
  input  logic            lsr_err,
  input  logic            rx_ready,
  input  logic            rx_tmo,
  input  logic            thr_empty,
  input  logic            msr_delta,
  input  logic            rd_iir,
  input  logic            rd_lsr,
  input  logic            rd_msr,
  input  logic            wr_thr,
  output logic [ID_W-1:0] iir,
  output logic            irq
);
  logic [SF_N-1:0]   sf_set, sf_clr, sf_pend;
  logic [CODE_W-1:0] code;
  logic [ID_W-1:0]   live_id;
  logic              rd_start;
  logic              thr_q;

  // edge detect on holding-register empty; reset high so no edge fires at start-up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= 1'b1;
    else        thr_q <= thr_empty;
  end

  always_comb begin
    sf_set           = '0;
    sf_clr           = '0;
    sf_set[SF_LINE]  = lsr_err;
    sf_clr[SF_LINE]  = rd_lsr;
    sf_set[SF_MODEM] = msr_delta;
    sf_clr[SF_MODEM] = rd_msr;
    sf_set[SF_TXE]   = thr_empty & ~thr_q;
    sf_clr[SF_TXE]   = wr_thr | (rd_start & (code == ID_TXE));
  end

  uirq_sticky #(.N(SF_N)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sf_set),
    .clr_i (sf_clr),
    .pend_o(sf_pend)
  );

  uirq_prio u_prio (
    .line_i (sf_pend[SF_LINE]  & ien[2]),
    .tmo_i  (rx_tmo & fifo_en  & ien[0]),
    .rxd_i  (rx_ready          & ien[0]),
    .txe_i  (sf_pend[SF_TXE]   & ien[1]),
    .modem_i(sf_pend[SF_MODEM] & ien[3]),
    .code_o (code),
    .any_o  (irq)
  );

  assign live_id = {fifo_en, fifo_en, 2'b00, code};

  uirq_snap #(.W(ID_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_i      (rd_iir),
    .live_i    (live_id),
    .rd_start_o(rd_start),
    .view_o    (iir)
  );
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ien,
  input logic       fifo_en,
  input logic       lsr_err,
  input logic       thr_empty,
  input logic       msr_delta,
  input logic       rd_iir,
  input logic       wr_thr,
  input logic [7:0] iir,
  input logic       irq
);
  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_iir |-> (irq == !iir[0]));  // R6
  AST_NO_IRQ_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'b0000) |-> !irq);  // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    iir[5:4] == 2'b00);  // R4
  AST_FIFO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_iir |-> (iir[7:6] == {2{fifo_en}}));  // R4
  AST_NO_TMO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !rd_iir) |-> !iir[3]);  // R3
  AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lsr_err) && ien[2] && !rd_iir) |-> (iir[3:0] == 4'b0110));  // R7
  AST_MODEM_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(msr_delta) && ien[3] && !rd_iir) |-> irq);  // R8
  AST_TXE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_thr) && !$past(thr_empty) && !rd_iir) |-> (iir[3:0] != 4'b0010));  // R10
  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rd_iir && $past(rd_iir)) |-> $stable(iir));  // R11
endmodule

bind uirq_top uirq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ien      (ien),
  .fifo_en  (fifo_en),
  .lsr_err  (lsr_err),
  .thr_empty(thr_empty),
  .msr_delta(msr_delta),
  .rd_iir   (rd_iir),
  .wr_thr   (wr_thr),
  .iir      (iir),
  .irq      (irq)
);

// File: tb/uirq_top_bench.sv
`timescale 1ns/1ps
module uirq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ien;
  logic       fifo_en, lsr_err, rx_ready, rx_tmo, thr_empty, msr_delta;
  logic       rd_iir, rd_lsr, rd_msr, wr_thr;
  logic [7:0] iir;
  logic       irq;

  int  n_chk  = 0;
  int  n_err  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  uirq_top u_uirq_top (
    .clk(clk), .rst_n(rst_n), .ien(ien), .fifo_en(fifo_en),
    .lsr_err(lsr_err), .rx_ready(rx_ready), .rx_tmo(rx_tmo),
    .thr_empty(thr_empty), .msr_delta(msr_delta), .rd_iir(rd_iir),
    .rd_lsr(rd_lsr), .rd_msr(rd_msr), .wr_thr(wr_thr), .iir(iir), .irq(irq)
  );

  function automatic logic [7:0] exp_id(bit ls, bit rx, bit to, bit te, bit ms,
                                        bit [3:0] en, bit f);
    logic [3:0] c;
    if (ls && en[2])           c = 4'b0110;
    else if (f && to && en[0]) c = 4'b1100;
    else if (rx && en[0])      c = 4'b0100;
    else if (te && en[1])      c = 4'b0010;
    else if (ms && en[3])      c = 4'b0000;
    else                       c = 4'b0001;
    return {f, f, 2'b00, c};
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop_strobes();
    lsr_err = 0; msr_delta = 0; rd_iir = 0; rd_lsr = 0; rd_msr = 0; wr_thr = 0;
  endtask

  task automatic clear_all();
    drop_strobes();
    rd_lsr = 1; rd_msr = 1; wr_thr = 1; thr_empty = 0;
    cyc();
    drop_strobes();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ien = 0; fifo_en = 0; rx_ready = 0; rx_tmo = 0; thr_empty = 0;
    drop_strobes();
    repeat (3) @(negedge clk);
    chk("R12 reset iir", iir, 8'h01);
    chk("R12 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    cyc();
    chk("R12 after release", iir, 8'h01);

    // R1 R2 R3 R4 R5 R6 R9: exhaustive sweep of pending mix, enables, mode
    for (int f = 0; f < 2; f++) begin
      for (int en = 0; en < 16; en++) begin
        for (int m = 0; m < 32; m++) begin
          logic [7:0] e;
          clear_all();
          ien = en[3:0]; fifo_en = f[0];
          lsr_err = m[0]; rx_ready = m[1]; rx_tmo = m[2];
          thr_empty = m[3]; msr_delta = m[4];
          cyc();
          drop_strobes();
          e = exp_id(m[0], m[1], m[2], m[3], m[4], en[3:0], f[0]);
          chk("R1 R2 R3 R4 R5 sweep iir", iir, e);
          chk("R6 sweep irq", {7'd0, irq}, {7'd0, ~e[0]});
        end
      end
    end
    rx_ready = 0; rx_tmo = 0; fifo_en = 0;

    // R7: simultaneous error and clear leaves flag set
    clear_all(); ien = 4'b0100;
    lsr_err = 1; rd_lsr = 1; cyc(); drop_strobes();
    chk("R7 set beats clear", iir, 8'h06);
    rd_lsr = 1; cyc(); drop_strobes();
    chk("R7 read clears", iir, 8'h01);

    // R8: simultaneous modem change and read
    ien = 4'b1000;
    msr_delta = 1; rd_msr = 1; cyc(); drop_strobes();
    chk("R8 set beats clear", iir, 8'h00);
    rd_msr = 1; cyc(); drop_strobes();
    chk("R8 read clears", iir, 8'h01);

    // R5: latched while disabled, shown once enabled
    ien = 4'b0000; msr_delta = 1; cyc(); drop_strobes();
    chk("R5 masked irq", {7'd0, irq}, 8'h00);
    ien = 4'b1000; #1;
    chk("R5 unmasked shows", iir, 8'h00);
    clear_all();

    // R9: data source follows level immediately
    ien = 4'b0001; rx_ready = 1; #1;
    chk("R9 level up", iir, 8'h04);
    rx_ready = 0; #1;
    chk("R9 level down", iir, 8'h01);

    // R10: identification read clears holding-empty when it is reported
    clear_all(); ien = 4'b0010; thr_empty = 1; cyc();
    chk("R10 holding empty set", iir, 8'h02);
    rd_iir = 1; #1;
    chk("R10 read shows code", iir, 8'h02);
    cyc(); rd_iir = 0; #1;
    chk("R10 cleared by read", iir, 8'h01);
    thr_empty = 1; cyc();
    chk("R10 no edge no set", iir, 8'h01);

    // R10: read reporting line error leaves holding-empty set
    clear_all(); ien = 4'b0110; thr_empty = 1; lsr_err = 1; cyc(); drop_strobes();
    chk("R10 line over holding", iir, 8'h06);
    rd_iir = 1; cyc(); rd_iir = 0; rd_lsr = 1; cyc(); drop_strobes();
    chk("R10 holding kept", iir, 8'h02);
    wr_thr = 1; cyc(); drop_strobes();
    chk("R10 write clears", iir, 8'h01);

    // R11: multi-cycle read freezes the byte
    clear_all(); ien = 4'b0100; lsr_err = 1; cyc(); drop_strobes();
    rd_iir = 1; #1;
    chk("R11 first cycle", iir, 8'h06);
    cyc(); ien = 4'b0000; fifo_en = 1; #1;
    chk("R11 held", iir, 8'h06);
    cyc();
    chk("R11 still held", iir, 8'h06);
    rd_iir = 0; #1;
    chk("R11 live after", iir, 8'hC1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule